// File: doc/BRIEF.md
# Two-Backplane Multiplexed LCD Segment and Common Driver

This block produces the drive pattern for a passive liquid crystal panel that has two common planes (backplanes) and a set of segment lines. It runs at 1/2 duty with half bias. A frame has four phases. In each phase one backplane is driven to a full rail and the other sits at mid-rail. Every segment line is set to the rail that turns the addressed segment on (the rail opposite the active backplane) or off (the same rail). Over a frame each backplane is driven once to the high rail and once to the low rail, so the glass sees no net DC.

Mid-rail is not made on chip. Each backplane has two pins with separate output enables that feed an external resistor divider. For a full-rail level the first pin drives the rail and the second is released. For mid-rail both pins are driven, the first high and the second low, and the divider settles at half supply. A one-cycle `tick` from an external timebase ends each phase; 5 ms per phase gives the usual 20 ms frame. Each segment line serves two segments, one per backplane. The bitmaps `seg_on_a` (backplane 0) and `seg_on_b` (backplane 1) supply the on bits and are sampled only on a tick.

The phase sequencer is a four-state machine with states PH0, PH1, PH2 and PH3. Reset places it in PH0. On every tick it takes the step transition to the next lower state, and from PH0 it wraps to PH3. Without a tick it holds. Because reset parks it in PH0, the first phase actually shown after reset is PH3. Before that first tick both backplanes rest at mid-rail and all segments are low.

Top module: `lcd2bp_driver`

## Requirements
- R1: After synchronous reset (`rst`=1), every `seg_out` bit is 0 and both backplanes are at mid-rail (`bpX_oe`=2'b11, `bpX_drv`=2'b01). This holds until the first tick.
- R2: Each `tick` steps the phase down by one, modulo 4. The first tick after reset enters phase 3, and the following ticks give 2, 1, 0, 3, and so on. Without a tick the outputs do not change.
- R3: Phase 0: backplane 0 high, backplane 1 mid. Phase 1: backplane 0 mid, backplane 1 high. Phase 2: backplane 0 low, backplane 1 mid. Phase 3: backplane 0 mid, backplane 1 low. At no time are both backplanes at a full rail.
- R4: Pin encoding per backplane, bit 0 = first pin, bit 1 = second pin. High: drv=2'b01, oe=2'b01. Low: drv=2'b00, oe=2'b01. Mid: drv=2'b01, oe=2'b11. A released pin's drv bit is 0.
- R5: In phases 0 and 2, `seg_out[i]` takes its on bit from `seg_on_a[i]`. In phases 1 and 3 it takes it from `seg_on_b[i]`.
- R6: `seg_out[i]` = on bit XOR P, where P=1 in phases 0 and 1 (active backplane high) and P=0 in phases 2 and 3. An on segment is therefore driven opposite to the active backplane, and an off segment is driven to the same rail.
- R7: `seg_on_a` and `seg_on_b` are sampled only on the clock edge that sees `tick`=1. Changes between ticks have no effect on any output.
- R8: All segment and backplane outputs change on the same clock edge, the one on which `tick` is sampled high.
- R9: With constant bitmaps, over any four consecutive phases each segment line is high in exactly two of them, and each backplane is high once, low once and mid twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle phase advance strobe |
| seg_on_a | input | SEG_LINES | On bits for segments addressed by backplane 0 |
| seg_on_b | input | SEG_LINES | On bits for segments addressed by backplane 1 |
| seg_out | output | SEG_LINES | Segment line levels |
| bp0_drv | output | 2 | Backplane 0 pin data (bit 0 first pin) |
| bp0_oe | output | 2 | Backplane 0 pin output enables |
| bp1_drv | output | 2 | Backplane 1 pin data |
| bp1_oe | output | 2 | Backplane 1 pin output enables |

## Verification
A wrong phase state shows up at the backplane pins on the very edge of the next tick: the pair of backplane levels identifies the phase without ambiguity, so a skipped, repeated or reversed phase is caught one cycle after that tick. A wrong bitmap selection or polarity shows at `seg_out` in the same cycle. The bench uses several bitmap patterns so that the A and B bits differ, which separates a wrong source from a wrong polarity. Sampling faults, where a bitmap leaks in between ticks, are checked by changing the inputs mid-phase and reading the outputs before the next tick.

// File: rtl/lcd2_pkg.sv
package lcd2_pkg;

    localparam int unsigned BP_COUNT    = 2;
    localparam int unsigned PHASE_COUNT = 2 * BP_COUNT;

    typedef enum logic [1:0] {
        PH0 = 2'd0,
        PH1 = 2'd1,
        PH2 = 2'd2,
        PH3 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        LV_MID  = 2'd0,
        LV_HIGH = 2'd1,
        LV_LOW  = 2'd2
    } level_e;

    // Bit 0 of the phase picks the active backplane, bit 1 picks its rail.
    function automatic level_e bp_level(input phase_e ph, input logic idx);
        level_e lv;
        if (ph[0] == idx)
            lv = ph[1] ? LV_LOW : LV_HIGH;
        else
            lv = LV_MID;
        return lv;
    endfunction

    // 1 while the active backplane sits at the high rail.
    function automatic logic phase_pol(input phase_e ph);
        return ~ph[1];
    endfunction

    // 1 when the segment bit comes from the backplane-1 bitmap.
    function automatic logic phase_sel_b(input phase_e ph);
        return ph[0];
    endfunction

endpackage

// File: rtl/lcd2_phase_seq.sv
module lcd2_phase_seq
    import lcd2_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    output phase_e phase_q,
    output phase_e phase_nx,
    output logic   adv
);

    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PH0;
        else
            state_q <= state_d;
    end

    // Step transition: downward, wrapping PH0 -> PH3.
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                PH0: state_d = PH3;
                PH3: state_d = PH2;
                PH2: state_d = PH1;
                PH1: state_d = PH0;
                default: state_d = PH0;
            endcase
        end
    end

    assign phase_q  = state_q;
    assign phase_nx = state_d;
    assign adv      = tick;

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (state_q == phase_e'($past(state_q) - 2'd1)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state_q));

endmodule

// File: rtl/lcd2_bp_pins.sv
module lcd2_bp_pins
    import lcd2_pkg::*;
#(
    parameter logic IDX = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  phase_e     phase_nx,
    output logic [1:0] drv_q,
    output logic [1:0] oe_q
);

    level_e     lv;
    logic [1:0] drv_d;
    logic [1:0] oe_d;

    assign lv = bp_level(phase_nx, IDX);

    always_comb begin
        unique case (lv)
            LV_HIGH: begin drv_d = 2'b01; oe_d = 2'b01; end
            LV_LOW:  begin drv_d = 2'b00; oe_d = 2'b01; end
            default: begin drv_d = 2'b01; oe_d = 2'b11; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= 2'b01;
            oe_q  <= 2'b11;
        end else if (adv) begin
            drv_q <= drv_d;
            oe_q  <= oe_d;
        end
    end

    p_oe_legal_r4: assert property (@(posedge clk) disable iff (rst)
        (oe_q == 2'b01) || (oe_q == 2'b11));

    p_released_low_r4: assert property (@(posedge clk) disable iff (rst)
        (oe_q == 2'b01) |-> (drv_q[1] == 1'b0));

    p_pins_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(drv_q) && $stable(oe_q)));

endmodule

// File: rtl/lcd2_seg_drv.sv
module lcd2_seg_drv
    import lcd2_pkg::*;
#(
    parameter int unsigned SEG_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  phase_e               phase_nx,
    input  logic [SEG_LINES-1:0] seg_on_a,
    input  logic [SEG_LINES-1:0] seg_on_b,
    output logic [SEG_LINES-1:0] seg_q
);

    logic pol;
    logic sel_b;

    assign pol   = phase_pol(phase_nx);
    assign sel_b = phase_sel_b(phase_nx);

    for (genvar i = 0; i < SEG_LINES; i++) begin : g_line
        logic on_bit;
        assign on_bit = sel_b ? seg_on_b[i] : seg_on_a[i];
        always_ff @(posedge clk) begin
            if (rst)
                seg_q[i] <= 1'b0;
            else if (adv)
                seg_q[i] <= on_bit ^ pol;
        end
    end

    p_seg_sample_r7: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(seg_q));

endmodule

// File: rtl/lcd2bp_driver.sv
module lcd2bp_driver
    import lcd2_pkg::*;
#(
    parameter int unsigned SEG_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [SEG_LINES-1:0] seg_on_a,
    input  logic [SEG_LINES-1:0] seg_on_b,
    output logic [SEG_LINES-1:0] seg_out,
    output logic [1:0]           bp0_drv,
    output logic [1:0]           bp0_oe,
    output logic [1:0]           bp1_drv,
    output logic [1:0]           bp1_oe
);

    phase_e     phase_q;
    phase_e     phase_nx;
    logic       adv;
    logic [1:0] drv_w [BP_COUNT];
    logic [1:0] oe_w  [BP_COUNT];

    lcd2_phase_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .phase_q  (phase_q),
        .phase_nx (phase_nx),
        .adv      (adv)
    );

    for (genvar b = 0; b < BP_COUNT; b++) begin : g_bp
        lcd2_bp_pins #(.IDX(1'(b))) u_pins (
            .clk      (clk),
            .rst      (rst),
            .adv      (adv),
            .phase_nx (phase_nx),
            .drv_q    (drv_w[b]),
            .oe_q     (oe_w[b])
        );
    end

    lcd2_seg_drv #(.SEG_LINES(SEG_LINES)) u_seg (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .phase_nx (phase_nx),
        .seg_on_a (seg_on_a),
        .seg_on_b (seg_on_b),
        .seg_q    (seg_out)
    );

    assign bp0_drv = drv_w[0];
    assign bp0_oe  = oe_w[0];
    assign bp1_drv = drv_w[1];
    assign bp1_oe  = oe_w[1];

    p_one_active_r3: assert property (@(posedge clk) disable iff (rst)
        $countones({bp0_oe == 2'b01, bp1_oe == 2'b01}) <= 1);

    p_active_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> ($countones({bp0_oe == 2'b01, bp1_oe == 2'b01}) == 1));

    // Backplane level and segment rail both follow the phase register.
    p_phase_match_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH0 && bp0_oe == 2'b01) |-> (bp0_drv == 2'b01));

endmodule

// File: tb/lcd2bp_driver_bench.sv
`timescale 1ns/1ps
module lcd2bp_driver_bench;

    localparam int unsigned SEG_LINES = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 tick = 1'b0;
    logic [SEG_LINES-1:0] seg_on_a = '0;
    logic [SEG_LINES-1:0] seg_on_b = '0;
    logic [SEG_LINES-1:0] seg_out;
    logic [1:0]           bp0_drv, bp0_oe, bp1_drv, bp1_oe;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_ph   = 0;
    logic [SEG_LINES-1:0] lat_a = '0;
    logic [SEG_LINES-1:0] lat_b = '0;

    always #2 clk = ~clk;

    lcd2bp_driver #(.SEG_LINES(SEG_LINES)) u_lcd2bp_driver (
        .clk(clk), .rst(rst), .tick(tick),
        .seg_on_a(seg_on_a), .seg_on_b(seg_on_b), .seg_out(seg_out),
        .bp0_drv(bp0_drv), .bp0_oe(bp0_oe), .bp1_drv(bp1_drv), .bp1_oe(bp1_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h (phase %0d)", req, act, exp, exp_ph);
        end
    endtask

    // 0 mid, 1 high, 2 low
    function automatic int lvl_of(input int bp, input int ph);
        if (bp == 0) return (ph == 0) ? 1 : (ph == 2) ? 2 : 0;
        return (ph == 1) ? 1 : (ph == 3) ? 2 : 0;
    endfunction

    function automatic logic [3:0] pins_of(input int lv);
        // {drv, oe}
        if (lv == 1) return 4'b0101;
        if (lv == 2) return 4'b0001;
        return 4'b0111;
    endfunction

    function automatic logic [SEG_LINES-1:0] seg_exp(input int ph,
        input logic [SEG_LINES-1:0] a, input logic [SEG_LINES-1:0] b);
        logic [SEG_LINES-1:0] src;
        src = (ph == 0 || ph == 2) ? a : b;
        return (ph < 2) ? ~src : src;
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " R3 R4 bp0"}, {28'd0, bp0_drv, bp0_oe}, {28'd0, pins_of(lvl_of(0, exp_ph))});
        chk({tag, " R3 R4 bp1"}, {28'd0, bp1_drv, bp1_oe}, {28'd0, pins_of(lvl_of(1, exp_ph))});
        chk({tag, " R5 R6 seg"}, 32'(seg_out), 32'(seg_exp(exp_ph, lat_a, lat_b)));
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        lat_a = seg_on_a;
        lat_b = seg_on_b;
        @(negedge clk);
        tick = 1'b0;
        exp_ph = (exp_ph + 3) % 4;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        seg_on_a = 16'hFFFF;
        seg_on_b = 16'hA5A5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 seg low", 32'(seg_out), 32'd0);
        chk("R1 bp0 mid", {28'd0, bp0_drv, bp0_oe}, 32'h7);
        chk("R1 bp1 mid", {28'd0, bp1_drv, bp1_oe}, 32'h7);
        exp_ph = 0;
    endtask

    task automatic t_sequence();
        // R2: first phase after reset is 3, then 2,1,0,3
        seg_on_a = 16'h0F0F;
        seg_on_b = 16'h3C3C;
        for (int k = 0; k < 6; k++) begin
            do_tick();
            check_all("R2 seq");
        end
        // R2 hold: no tick, nothing moves
        repeat (7) @(negedge clk);
        check_all("R2 hold");
    endtask

    task automatic t_patterns();
        logic [SEG_LINES-1:0] pa [4] = '{16'h0000, 16'hFFFF, 16'h1234, 16'h8001};
        logic [SEG_LINES-1:0] pb [4] = '{16'hFFFF, 16'h0000, 16'hEDCB, 16'h7FFE};
        for (int p = 0; p < 4; p++) begin
            seg_on_a = pa[p];
            seg_on_b = pb[p];
            for (int k = 0; k < 4; k++) begin
                do_tick();
                check_all("R5 R6 R8 pattern");
            end
        end
    endtask

    task automatic t_ignore();
        seg_on_a = 16'h00FF;
        seg_on_b = 16'hFF00;
        do_tick();
        check_all("R7 base");
        seg_on_a = 16'hAAAA;
        seg_on_b = 16'h5555;
        repeat (5) @(negedge clk);
        check_all("R7 ignored mid-phase");
        seg_on_a = 16'h1111;
        @(negedge clk);
        check_all("R7 ignored second change");
        do_tick();
        check_all("R7 taken at tick");
    endtask

    task automatic t_balance();
        int hi [SEG_LINES];
        int bh [2];
        int bl [2];
        int bm [2];
        for (int i = 0; i < SEG_LINES; i++) hi[i] = 0;
        for (int b = 0; b < 2; b++) begin bh[b] = 0; bl[b] = 0; bm[b] = 0; end
        seg_on_a = 16'hC3A1;
        seg_on_b = 16'h5E17;
        for (int k = 0; k < 4; k++) begin
            do_tick();
            for (int i = 0; i < SEG_LINES; i++) hi[i] += int'(seg_out[i]);
            if (bp0_oe == 2'b11) bm[0]++; else if (bp0_drv[0]) bh[0]++; else bl[0]++;
            if (bp1_oe == 2'b11) bm[1]++; else if (bp1_drv[0]) bh[1]++; else bl[1]++;
        end
        for (int i = 0; i < SEG_LINES; i++) chk("R9 seg balance", 32'(hi[i]), 32'd2);
        for (int b = 0; b < 2; b++) begin
            chk("R9 bp high once", 32'(bh[b]), 32'd1);
            chk("R9 bp low once", 32'(bl[b]), 32'd1);
            chk("R9 bp mid twice", 32'(bm[b]), 32'd2);
        end
    endtask

    task automatic t_reset_mid_run();
        do_tick();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid-run seg", 32'(seg_out), 32'd0);
        chk("R1 reset mid-run bp0", {28'd0, bp0_drv, bp0_oe}, 32'h7);
        chk("R1 reset mid-run bp1", {28'd0, bp1_drv, bp1_oe}, 32'h7);
        exp_ph = 0;
        seg_on_a = 16'h0001;
        seg_on_b = 16'h0002;
        do_tick();
        check_all("R2 first phase is 3 after reset");
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_patterns();
        t_ignore();
        t_balance();
        t_reset_mid_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #200000;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule